// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block sits on the programmer side of a four-wire in-system programming link. It drives a target device's clock, data-out and reset lines and reads the target's data-in line. On each `start` it pulses the target reset and waits out the target's startup time. It then shifts a four-byte enable instruction and checks that the target echoes the second opcode byte while the third byte goes out. If the echo is missing, it pulses reset again and retries, up to a limit.

Once the link is in sync, the block streams one page of program bytes from a valid/ready byte interface. Each byte becomes one load instruction that carries the in-page offset and the data. A write-page instruction carrying the page number then commits the page. The block then waits for the write to complete. If the page held at least one byte that is not 0xFF, it reads that byte back until it matches, because a busy target answers 0xFF. A page made only of 0xFF bytes cannot be confirmed this way, so for such a page the block waits a fixed number of cycles instead. The outcome is a one-cycle `done` pulse or a held error code.

All widths, timings, limits and opcode bytes are parameters. Every instruction is 32 bits long and is sent most significant bit first.

Top module: `isp_host_seq`

## Requirements
- R1: `sck` idles low. Each `sck` high and low phase lasts SCK_HALF clocks. `mosi` changes only while `sck` is low, so the target samples it on the rising edge. `miso` is sampled when `sck` falls.
- R2: After `start`, `tgt_reset` is high for RST_CYC clocks (at most one more) with `sck` held low. At least BOOT_CYC clocks then pass before the first `sck` rise.
- R3: The enable instruction is bytes 0xAC, 0x53, 0x00, 0x00 in that order. All 32 bits are always sent, whatever the echo.
- R4: An enable attempt succeeds only if the byte received during the third byte equals 0x53. On failure, `tgt_reset` is pulsed again (R2 timing) and the enable is resent.
- R5: After MAX_TRIES failed attempts, `err_code` becomes 1, `busy` drops, and no load, write or read instruction is sent.
- R6: `in_ready` is high only while the block waits for a page byte. The k-th accepted byte (k = 0 .. 2**OFF_W-1) is sent as the instruction 0x40, 0x00, k, data.
- R7: After the last load, the page is committed with the instruction 0x4C, page, 0x00, 0x00, where page is `page_sel` captured at `start`.
- R8: If any byte of the page is not 0xFF, the first such byte in load order is polled with the instruction 0x20, page, offset, 0x00. The fourth received byte is compared with the loaded value. `done` pulses on a match; any other value causes another read.
- R9: If every byte of the page is 0xFF, no read is sent. `done` pulses no earlier than WAIT_CYC clocks after the commit instruction.
- R10: After POLL_MAX reads without a match, `err_code` becomes 2 and `busy` drops.
- R11: `done` is a single-cycle pulse and never coincides with a nonzero `err_code`. `err_code` clears to 0 on the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session for one page (accepted when idle) |
| page_sel | input | PG_W | Page number placed in the commit and read instructions |
| in_valid | input | 1 | Page byte offered |
| in_data | input | 8 | Page byte value |
| in_ready | output | 1 | Block takes `in_data` on this cycle when `in_valid` is high |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| tgt_reset | output | 1 | Target reset line, active high |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse when the page is confirmed written |
| err_code | output | 2 | 0 none, 1 enable never in sync, 2 poll limit reached |

## Verification
A wrong sequencer state shows up at the target side within one instruction time (32 × 2 × SCK_HALF clocks). The target model then logs a misformed frame, a wrong offset or page, an extra reset pulse, or a wrong count of enable, load or read frames. A wrong echo or poll comparison shows up as too many or too few reset pulses or reads, or as a `done` pulse where an error was due. Fault-free pages are only distinguishable from all-0xFF pages by whether reads appear at all and by how long the block waits before `done`.

// File: rtl/isp_pkg.sv
package isp_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST,
    S_BOOT,
    S_EN,
    S_EN_W,
    S_LOAD,
    S_LOAD_W,
    S_WR,
    S_WR_W,
    S_RD,
    S_RD_W,
    S_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_SYNC = 2'd1,
    ERR_POLL = 2'd2
  } seq_err_e;

  localparam int FRAME_BITS = 32;

endpackage

// File: rtl/isp_delay.sv
module isp_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= value;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/isp_frame_shift.sv
module isp_frame_shift #(
  parameter int SCK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic [31:0] tx,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        fin,
  output logic [15:0] rx_tail
);

  localparam int DIV_W = $clog2(SCK_HALF + 1);
  localparam int BIT_W = $clog2(isp_pkg::FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(isp_pkg::FRAME_BITS - 1);

  logic              act_q;
  logic              sck_q;
  logic              fin_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [31:0]       sr_q;
  logic [15:0]       rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      sck_q <= 1'b0;
      fin_q <= 1'b0;
      div_q <= '0;
      bit_q <= '0;
      sr_q  <= '0;
      rx_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go && !act_q) begin
        act_q <= 1'b1;
        sck_q <= 1'b0;
        div_q <= '0;
        bit_q <= '0;
        sr_q  <= tx;
        rx_q  <= '0;
      end else if (act_q) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            rx_q  <= {rx_q[14:0], miso};
            if (bit_q == BIT_LAST) begin
              act_q <= 1'b0;
              fin_q <= 1'b1;
              sr_q  <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
              sr_q  <= {sr_q[30:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = sr_q[31];
  assign fin     = fin_q;
  assign rx_tail = rx_q;

endmodule

// File: rtl/isp_host_seq.sv
module isp_host_seq
  import isp_pkg::*;
#(
  parameter int SCK_HALF  = 4,
  parameter int RST_CYC   = 8,
  parameter int BOOT_CYC  = 1_000_000,
  parameter int WAIT_CYC  = 250_000,
  parameter int MAX_TRIES = 4,
  parameter int POLL_MAX  = 64,
  parameter int OFF_W     = 6,
  parameter int PG_W      = 7,
  parameter logic [7:0] OP_EN0   = 8'hAC,
  parameter logic [7:0] OP_EN1   = 8'h53,
  parameter logic [7:0] OP_EN2   = 8'h00,
  parameter logic [7:0] OP_EN3   = 8'h00,
  parameter logic [7:0] OP_LOAD  = 8'h40,
  parameter logic [7:0] OP_WPAGE = 8'h4C,
  parameter logic [7:0] OP_READ  = 8'h20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [PG_W-1:0] page_sel,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            tgt_reset,
  output logic            busy,
  output logic            done,
  output logic [1:0]      err_code
);

  localparam int T_MAX1 = (BOOT_CYC > WAIT_CYC) ? BOOT_CYC : WAIT_CYC;
  localparam int T_MAX  = (T_MAX1 > RST_CYC) ? T_MAX1 : RST_CYC;
  localparam int TMR_W  = $clog2(T_MAX + 1);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [OFF_W-1:0] OFF_LAST = {OFF_W{1'b1}};
  localparam logic [TMR_W-1:0] T_RST  = TMR_W'(RST_CYC - 1);
  localparam logic [TMR_W-1:0] T_BOOT = TMR_W'(BOOT_CYC - 1);
  localparam logic [TMR_W-1:0] T_WAIT = TMR_W'(WAIT_CYC - 1);
  localparam logic [TRY_W-1:0] TRY_LAST   = TRY_W'(MAX_TRIES - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

  seq_state_e        st_q, st_d;
  seq_err_e          err_q, err_d;
  logic [TRY_W-1:0]  tries_q, tries_d;
  logic [POLL_W-1:0] polls_q, polls_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [OFF_W-1:0]  poff_q, poff_d;
  logic [7:0]        pval_q, pval_d;
  logic              have_q, have_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic              trst_q, trst_d;
  logic              done_q, done_d;

  logic              sh_go;
  logic [31:0]       sh_tx;
  logic              sh_fin;
  logic [15:0]       sh_rx;
  logic              tmr_ld;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;

  isp_frame_shift #(
    .SCK_HALF(SCK_HALF)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .go      (sh_go),
    .tx      (sh_tx),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .fin     (sh_fin),
    .rx_tail (sh_rx)
  );

  isp_delay #(
    .W(TMR_W)
  ) u_delay (
    .clk   (clk),
    .rst   (rst),
    .load  (tmr_ld),
    .value (tmr_val),
    .zero  (tmr_zero)
  );

  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    tries_d = tries_q;
    polls_d = polls_q;
    off_d   = off_q;
    poff_d  = poff_q;
    pval_d  = pval_q;
    have_d  = have_q;
    page_d  = page_q;
    trst_d  = trst_q;
    done_d  = 1'b0;
    sh_go   = 1'b0;
    sh_tx   = '0;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          err_d   = ERR_NONE;
          tries_d = '0;
          page_d  = page_sel;
          trst_d  = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = T_RST;
          st_d    = S_RST;
        end
      end
      S_RST: begin
        if (tmr_zero) begin
          trst_d  = 1'b0;
          tmr_ld  = 1'b1;
          tmr_val = T_BOOT;
          st_d    = S_BOOT;
        end
      end
      S_BOOT: begin
        if (tmr_zero) st_d = S_EN;
      end
      S_EN: begin
        sh_go = 1'b1;
        sh_tx = {OP_EN0, OP_EN1, OP_EN2, OP_EN3};
        st_d  = S_EN_W;
      end
      S_EN_W: begin
        if (sh_fin) begin
          if (sh_rx[15:8] == OP_EN1) begin
            off_d  = '0;
            have_d = 1'b0;
            st_d   = S_LOAD;
          end else if (tries_q == TRY_LAST) begin
            err_d = ERR_SYNC;
            st_d  = S_IDLE;
          end else begin
            tries_d = tries_q + 1'b1;
            trst_d  = 1'b1;
            tmr_ld  = 1'b1;
            tmr_val = T_RST;
            st_d    = S_RST;
          end
        end
      end
      S_LOAD: begin
        if (in_valid) begin
          sh_go = 1'b1;
          sh_tx = {OP_LOAD, 8'h00, 8'(off_q), in_data};
          if (!have_q && (in_data != 8'hFF)) begin
            have_d = 1'b1;
            poff_d = off_q;
            pval_d = in_data;
          end
          st_d = S_LOAD_W;
        end
      end
      S_LOAD_W: begin
        if (sh_fin) begin
          if (off_q == OFF_LAST) begin
            st_d = S_WR;
          end else begin
            off_d = off_q + 1'b1;
            st_d  = S_LOAD;
          end
        end
      end
      S_WR: begin
        sh_go = 1'b1;
        sh_tx = {OP_WPAGE, 8'(page_q), 16'h0000};
        st_d  = S_WR_W;
      end
      S_WR_W: begin
        if (sh_fin) begin
          if (have_q) begin
            polls_d = '0;
            st_d    = S_RD;
          end else begin
            tmr_ld  = 1'b1;
            tmr_val = T_WAIT;
            st_d    = S_WAIT;
          end
        end
      end
      S_RD: begin
        sh_go = 1'b1;
        sh_tx = {OP_READ, 8'(page_q), 8'(poff_q), 8'h00};
        st_d  = S_RD_W;
      end
      S_RD_W: begin
        if (sh_fin) begin
          if (sh_rx[7:0] == pval_q) begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else if (polls_q == POLL_LAST) begin
            err_d = ERR_POLL;
            st_d  = S_IDLE;
          end else begin
            polls_d = polls_q + 1'b1;
            st_d    = S_RD;
          end
        end
      end
      S_WAIT: begin
        if (tmr_zero) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      err_q   <= ERR_NONE;
      tries_q <= '0;
      polls_q <= '0;
      off_q   <= '0;
      poff_q  <= '0;
      pval_q  <= '0;
      have_q  <= 1'b0;
      page_q  <= '0;
      trst_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      err_q   <= err_d;
      tries_q <= tries_d;
      polls_q <= polls_d;
      off_q   <= off_d;
      poff_q  <= poff_d;
      pval_q  <= pval_d;
      have_q  <= have_d;
      page_q  <= page_d;
      trst_q  <= trst_d;
      done_q  <= done_d;
    end
  end

  assign in_ready  = (st_q == S_LOAD);
  assign busy      = (st_q != S_IDLE);
  assign tgt_reset = trst_q;
  assign done      = done_q;
  assign err_code  = err_q;

endmodule

// File: rtl/isp_host_chk.sv
module isp_host_chk #(
  parameter int SCK_HALF = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       sck,
  input logic       mosi,
  input logic       tgt_reset,
  input logic       in_ready,
  input logic       busy,
  input logic       done,
  input logic [1:0] err_code
);

  localparam int HW = $clog2(SCK_HALF + 2);

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (sck) hi_run <= hi_run + 1'b1;
    else hi_run <= '0;
  end

  a_r1_mosi_steady: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));

  a_r1_sck_high_width: assert property (@(posedge clk) disable iff (rst)
    sck |-> (hi_run < HW'(SCK_HALF)));

  a_r2_sck_low_in_reset: assert property (@(posedge clk) disable iff (rst)
    tgt_reset |-> !sck);

  a_r6_ready_in_session: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (busy && !tgt_reset));

  a_r5_err_idle: assert property (@(posedge clk) disable iff (rst)
    (err_code != 2'd0) |-> !busy);

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_no_err: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_code == 2'd0));

endmodule

bind isp_host_seq isp_host_chk #(
  .SCK_HALF(SCK_HALF)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sck       (sck),
  .mosi      (mosi),
  .tgt_reset (tgt_reset),
  .in_ready  (in_ready),
  .busy      (busy),
  .done      (done),
  .err_code  (err_code)
);

// File: tb/sim_isp_host_seq.sv
module sim_isp_host_seq;

  localparam int SCK_HALF  = 2;
  localparam int RST_CYC   = 5;
  localparam int BOOT_CYC  = 40;
  localparam int WAIT_CYC  = 60;
  localparam int MAX_TRIES = 3;
  localparam int POLL_MAX  = 6;
  localparam int OFF_W     = 2;
  localparam int PG_W      = 7;
  localparam int NB        = 1 << OFF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PG_W-1:0] page_sel = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, sck, mosi, tgt_reset, busy, done;
  logic [1:0] err_code;
  logic tmiso = 1'b0;

  always #10 clk = ~clk;

  isp_host_seq #(
    .SCK_HALF(SCK_HALF), .RST_CYC(RST_CYC), .BOOT_CYC(BOOT_CYC),
    .WAIT_CYC(WAIT_CYC), .MAX_TRIES(MAX_TRIES), .POLL_MAX(POLL_MAX),
    .OFF_W(OFF_W), .PG_W(PG_W)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .page_sel(page_sel),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sck(sck), .mosi(mosi), .miso(tmiso), .tgt_reset(tgt_reset),
    .busy(busy), .done(done), .err_code(err_code)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  // target model state
  int fail_left, busy_cfg, busy_left, exp_poff;
  int n_en, n_ld, n_wr, n_rd, n_other, n_rst;
  int en_bad, ld_bad, rd_bad, ld_idx, wr_pg, t_wr;
  int bitk = 0;
  logic [31:0] tsh = '0;
  logic [7:0] b0, b1, b2, b3, resp;
  logic [7:0] pagebuf [NB];
  logic [7:0] committed [NB];

  always @(posedge sck or posedge tgt_reset) begin
    if (tgt_reset) begin
      bitk = 0;
    end else begin
      int k;
      k = bitk;
      tsh = {tsh[30:0], mosi};
      if (k == 7)  b0 = tsh[7:0];
      if (k == 15) b1 = tsh[7:0];
      if (k == 23) b2 = tsh[7:0];
      resp = 8'h00;
      if (k >= 16 && k <= 23 && b0 == 8'hAC) resp = (fail_left > 0) ? 8'h00 : b1;
      if (k >= 24 && b0 == 8'h20)
        resp = (busy_left > 0) ? 8'hFF : committed[b2[OFF_W-1:0]];
      tmiso = resp[7 - (k % 8)];
      if (k == 31) begin
        b3 = tsh[7:0];
        bitk = 0;
        case (b0)
          8'hAC: begin
            n_en++;
            if (b1 != 8'h53 || b2 != 8'h00 || b3 != 8'h00) en_bad++;
            if (fail_left > 0) fail_left--;
          end
          8'h40: begin
            n_ld++;
            if (b1 != 8'h00 || int'(b2) != ld_idx || ld_idx >= NB) ld_bad++;
            else pagebuf[b2[OFF_W-1:0]] = b3;
            ld_idx++;
          end
          8'h4C: begin
            n_wr++;
            wr_pg = int'(b1);
            for (int i = 0; i < NB; i++) committed[i] = pagebuf[i];
            busy_left = busy_cfg;
            t_wr = cyc;
          end
          8'h20: begin
            n_rd++;
            if (int'(b1) != int'(page_sel) || int'(b2) != exp_poff) rd_bad++;
            if (busy_left > 0) busy_left--;
          end
          default: n_other++;
        endcase
      end else begin
        bitk = k + 1;
      end
    end
  end

  always @(posedge tgt_reset) n_rst++;

  // port timing monitors
  int hcnt = 0, hi_bad = 0, rlen = 0, rlen_lo = 0, rlen_hi = 0;
  int gcnt = 0, gap_min = 0;
  bit armed = 0;

  always @(posedge clk) begin
    cyc++;
    if (sck) hcnt++;
    else if (hcnt != 0) begin
      if (hcnt != SCK_HALF) hi_bad++;
      hcnt = 0;
    end
    if (tgt_reset) rlen++;
    else if (rlen != 0) begin
      if (rlen < rlen_lo) rlen_lo = rlen;
      if (rlen > rlen_hi) rlen_hi = rlen;
      rlen = 0;
      armed = 1;
      gcnt = 0;
    end
    if (armed) begin
      if (sck) begin
        if (gcnt < gap_min) gap_min = gcnt;
        armed = 0;
      end else gcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic run_page(input int pg, input int pat, input int fails, input int bsy);
    logic [7:0] d [NB];
    int attempts, guard, t_done, first;
    bit got_done;
    for (int i = 0; i < NB; i++) begin
      d[i] = 8'((pg * 7 + i * 37 + bsy * 11 + fails * 3) % 255);
      if (pat == 2 || (pat == 1 && i < 2)) d[i] = 8'hFF;
    end
    first = -1;
    for (int i = NB - 1; i >= 0; i--) if (d[i] != 8'hFF) first = i;
    attempts = (fails >= MAX_TRIES) ? MAX_TRIES : fails + 1;
    fail_left = fails; busy_cfg = bsy; busy_left = 0; exp_poff = first;
    n_en = 0; n_ld = 0; n_wr = 0; n_rd = 0; n_other = 0; n_rst = 0;
    en_bad = 0; ld_bad = 0; rd_bad = 0; ld_idx = 0; wr_pg = -1; t_wr = 0;
    hi_bad = 0; rlen_lo = 1 << 30; rlen_hi = 0; gap_min = 1 << 30;
    for (int i = 0; i < NB; i++) pagebuf[i] = 8'h00;

    @(negedge clk);
    page_sel = PG_W'(pg);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err_code == 2'd0 && busy, "R11 err cleared on start", int'(err_code), 0);

    if (fails < MAX_TRIES) begin
      for (int i = 0; i < NB; i++) begin
        in_valid = 1'b1;
        in_data = d[i];
        guard = 0;
        while (!in_ready && guard < 20000) begin
          @(negedge clk);
          guard++;
        end
        @(negedge clk);
      end
      in_valid = 1'b0;
    end

    got_done = 0; guard = 0; t_done = 0;
    while (busy && guard < 20000) begin
      if (done) begin got_done = 1; t_done = cyc; end
      @(negedge clk);
      guard++;
    end
    if (done) begin got_done = 1; t_done = cyc; end
    @(negedge clk);
    chk(!done, "R11 done single cycle", int'(done), 0);

    chk(hi_bad == 0, "R1 sck high width", hi_bad, 0);
    chk(rlen_lo >= RST_CYC && rlen_hi <= RST_CYC + 1, "R2 reset pulse length", rlen_lo, RST_CYC);
    chk(gap_min >= BOOT_CYC, "R2 startup gap", gap_min, BOOT_CYC);
    chk(n_en == attempts && en_bad == 0, "R3 enable frames", n_en, attempts);
    chk(n_rst == attempts, "R4 reset pulses per attempt", n_rst, attempts);
    chk(n_other == 0, "R3 unknown frames", n_other, 0);
    if (fails >= MAX_TRIES) begin
      chk(err_code == 2'd1 && !got_done, "R5 sync error code", int'(err_code), 1);
      chk(n_ld + n_wr + n_rd == 0, "R5 nothing after sync failure", n_ld + n_wr + n_rd, 0);
    end else begin
      chk(n_ld == NB && ld_bad == 0, "R6 load frames", n_ld, NB);
      for (int i = 0; i < NB; i++)
        chk(pagebuf[i] == d[i], "R6 loaded byte", int'(pagebuf[i]), int'(d[i]));
      chk(n_wr == 1 && wr_pg == pg, "R7 commit page", wr_pg, pg);
      if (first < 0) begin
        chk(n_rd == 0, "R9 no reads for all-ones page", n_rd, 0);
        chk(got_done && (t_done - t_wr) >= WAIT_CYC, "R9 fixed wait", t_done - t_wr, WAIT_CYC);
      end else if (bsy >= POLL_MAX) begin
        chk(err_code == 2'd2 && !got_done, "R10 poll limit error", int'(err_code), 2);
        chk(n_rd == POLL_MAX, "R10 read count", n_rd, POLL_MAX);
      end else begin
        chk(got_done && err_code == 2'd0, "R8 done after poll", int'(got_done), 1);
        chk(n_rd == bsy + 1 && rd_bad == 0, "R8 read frames", n_rd, bsy + 1);
      end
    end
  endtask

  initial begin
    fail_left = 0; busy_cfg = 0; busy_left = 0; exp_poff = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!sck && !mosi && !tgt_reset && !busy && !done && !in_ready && err_code == 2'd0,
        "R1 reset state", int'({sck, mosi, tgt_reset, busy, done, in_ready}), 0);
    for (int f = 0; f <= MAX_TRIES; f++)
      for (int p = 0; p < 3; p++)
        for (int b = 0; b < 3; b++)
          run_page((f * 41 + p * 17 + b * 5) % 128, p, f, b);
    run_page(127, 0, 0, POLL_MAX + 2);
    run_page(1, 1, 0, POLL_MAX + 2);
    run_page(64, 0, 1, 0);
    finish_run();
  end

endmodule